// File: doc/BRIEF.md
# Programmable Link/Activity LED Driver

This block turns the status of a 10/100 Ethernet transceiver into the levels of two active-low indicator pins. It watches the link state, the line speed and a one-cycle strobe that pulses once per packet. A 2-bit mode field, taken from bits [15:14] of a control register kept elsewhere, decides what each pin shows. One mode pairs a combined link/activity lamp with a speed lamp. The other gives a lamp for link alone and a lamp for activity alone.

Activity is shown as blinking. A strobe opens a hold window of a fixed number of toggle periods. Each period is a parameterised number of system clocks. While the window is open, the activity-bearing lamp alternates between on and off. A new strobe inside the window extends it without breaking the rhythm of the blinking. The two reserved mode codes switch both lamps off. Each pin is registered, so its level reflects the inputs sampled at a clock edge and appears at the output after that same edge.

Top module: `led_status_drv`

## Requirements
- R1: A synchronous active-high reset clears the activity window, the blink phase and the prescaler. At the edge where reset is high, both pins go high (off).
- R2: In mode 2'b00, pin 1 is low when `speed_100` is 1 (100 Mb/s) and high when it is 0 (10 Mb/s). The pin shows the value sampled at the preceding clock edge.
- R3: In mode 2'b00, pin 0 is high whenever `link_up` is 0, even if strobes arrive. With the link up and no window open, pin 0 is low.
- R4: In mode 2'b00, with the link up and a window open, pin 0 is low during the lit half of the blink and high during the dark half.
- R5: In mode 2'b01, pin 0 is the inverse of `link_up` and is not affected by activity.
- R6: In mode 2'b01, pin 1 is high while no window is open and follows the blink (low when lit) while a window is open. The link state does not change it.
- R7: In modes 2'b10 and 2'b11, both pins are high whatever the link, speed and activity inputs are.
- R8: A tick occurs on every PRESCALE-th clock edge after reset. A strobe sets the window to HOLD_TOGGLES ticks. At each tick, if the window was already open before that edge, the blink phase inverts. A window opened from idle starts in the lit half.
- R9: A strobe that arrives while a window is open reloads the window to HOLD_TOGGLES ticks and leaves the blink phase unchanged.
- R10: Each tick with no strobe shortens an open window by one. Once it reaches zero, the activity lamp returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | 1 when the link is established |
| speed_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| act_strobe | input | 1 | One-cycle pulse per packet seen |
| led_mode | input | 2 | Mode: 00 link/activity + speed, 01 link + activity, 1x reserved |
| led0_n | output | 1 | Pin 0 level, low = lamp on |
| led1_n | output | 1 | Pin 1 level, low = lamp on |

## Verification
The bench compares both pins with a cycle model on every clock edge. It goes after these corner cases:

- **Strobes with the link down in mode 00.** A design that let activity through the link gate would blink a lamp that should stay dark.
- **A strobe in the middle of a window.** A design that restarted the phase would insert a stray lit segment. A design that did not reload the window would go dark too early.
- **Letting a window run out.** A wrong decrement or a wrong zero test shows up as too many or too few toggles.
- **The reserved codes.** These are driven while link, speed and strobes are active, and any leak of state shows up as a low pin.
- **A reset in the middle of a blink.** A design that kept its window or phase through reset would carry the blinking on after reset.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  typedef enum logic [1:0] {
    LEDM_LINKACT_SPEED = 2'b00,
    LEDM_LINK_ACT      = 2'b01,
    LEDM_RSVD_A        = 2'b10,
    LEDM_RSVD_B        = 2'b11
  } led_mode_e;

  // Active-high lamp requests produced by the mode decoder.
  typedef struct packed {
    logic lamp0;
    logic lamp1;
  } lamp_req_t;

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int PRESCALE = 1250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (PRESCALE <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q;

      assign tick = (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (tick) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      // R8: ticks are isolated pulses when the divider exceeds one
      a_r8_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
      a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    end
  endgenerate

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int HOLD_TOGGLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic strobe,
  output logic act_o,
  output logic lit_o
);

  localparam int HW = $clog2(HOLD_TOGGLES + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_TOGGLES);

  logic [HW-1:0] hold_q, hold_d;
  logic          ph_q, ph_d;

  always_comb begin
    hold_d = hold_q;
    if (strobe) begin
      hold_d = HOLD_LOAD;
    end else if (tick && (hold_q != '0)) begin
      hold_d = hold_q - 1'b1;
    end
    if (hold_q == '0) begin
      ph_d = 1'b0;
    end else if (tick) begin
      ph_d = ~ph_q;
    end else begin
      ph_d = ph_q;
    end
  end

  // The outputs look at the state being written, so the output register
  // in the top shows the same edge's result.
  assign act_o = (hold_d != '0);
  assign lit_o = act_o & ~ph_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      ph_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      ph_q   <= ph_d;
    end
  end

  // R1: reset leaves the window closed and the phase lit-first
  a_r1_clear: assert property (@(posedge clk)
    rst |=> (hold_q == '0) && !ph_q);
  // R8: the window never exceeds its load value
  a_r8_hold_bound: assert property (@(posedge clk) disable iff (rst)
    hold_q <= HOLD_LOAD);
  // R8: the phase only moves on a tick
  a_r8_phase_quiet: assert property (@(posedge clk) disable iff (rst)
    (hold_q != '0 && !tick) |=> ph_q == $past(ph_q));
  // R9: a strobe always reloads the full window
  a_r9_reload: assert property (@(posedge clk) disable iff (rst)
    strobe |=> hold_q == HOLD_LOAD);
  // R10: an undisturbed tick shortens an open window by one
  a_r10_decay: assert property (@(posedge clk) disable iff (rst)
    (tick && !strobe && hold_q != '0) |=> hold_q == $past(hold_q) - 1'b1);

endmodule

// File: rtl/led_mode_map.sv
module led_mode_map
  import led_drv_pkg::*;
(
  input  led_mode_e mode,
  input  logic      link_up,
  input  logic      speed_100,
  input  logic      act,
  input  logic      lit,
  output lamp_req_t req
);

  always_comb begin
    req = '0;
    case (mode)
      LEDM_LINKACT_SPEED: begin
        req.lamp0 = link_up & (~act | lit);
        req.lamp1 = speed_100;
      end
      LEDM_LINK_ACT: begin
        req.lamp0 = link_up;
        req.lamp1 = lit;
      end
      default: req = '0;
    endcase
  end

endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_drv_pkg::*;
#(
  parameter int PRESCALE     = 1250000,
  parameter int HOLD_TOGGLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_up,
  input  logic       speed_100,
  input  logic       act_strobe,
  input  logic [1:0] led_mode,
  output logic       led0_n,
  output logic       led1_n
);

  logic      tick;
  logic      act, lit;
  lamp_req_t req;

  led_tick_gen #(.PRESCALE(PRESCALE)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  led_blink_gen #(.HOLD_TOGGLES(HOLD_TOGGLES)) i_blink (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .strobe (act_strobe),
    .act_o  (act),
    .lit_o  (lit)
  );

  led_mode_map i_map (
    .mode      (led_mode_e'(led_mode)),
    .link_up   (link_up),
    .speed_100 (speed_100),
    .act       (act),
    .lit       (lit),
    .req       (req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led0_n <= 1'b1;
      led1_n <= 1'b1;
    end else begin
      led0_n <= ~req.lamp0;
      led1_n <= ~req.lamp1;
    end
  end

  // R1: reset forces both lamps off
  a_r1_pins_off: assert property (@(posedge clk)
    rst |=> led0_n && led1_n);
  // R7: reserved codes keep both lamps off
  a_r7_reserved: assert property (@(posedge clk) disable iff (rst)
    led_mode[1] |=> led0_n && led1_n);
  // R3: combined lamp stays dark with the link down
  a_r3_link_gate: assert property (@(posedge clk) disable iff (rst)
    (led_mode == 2'b00 && !link_up) |=> led0_n);
  // R2: speed lamp in mode 00
  a_r2_speed: assert property (@(posedge clk) disable iff (rst)
    (led_mode == 2'b00) |=> led1_n == !$past(speed_100));
  // R5: link-only lamp in mode 01
  a_r5_link_only: assert property (@(posedge clk) disable iff (rst)
    (led_mode == 2'b01) |=> led0_n == !$past(link_up));

endmodule

// File: tb/test_led_status_drv.sv
module test_led_status_drv;

  localparam int P = 4;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       link_up = 1'b0;
  logic       speed_100 = 1'b0;
  logic       act_strobe = 1'b0;
  logic [1:0] led_mode = 2'b00;
  logic       led0_n, led1_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  int m_cnt = 0;
  int m_hold = 0;
  bit m_ph = 1'b0;
  string section = "R1 reset";

  bit    q_e0[$];
  bit    q_e1[$];
  string q_t0[$];
  string q_t1[$];

  always #5 clk = ~clk;

  led_status_drv #(.PRESCALE(P), .HOLD_TOGGLES(H)) i_led_status_drv (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .speed_100  (speed_100),
    .act_strobe (act_strobe),
    .led_mode   (led_mode),
    .led0_n     (led0_n),
    .led1_n     (led1_n)
  );

  task automatic step(input logic [1:0] md, input bit lk, input bit sp,
                      input bit st, input bit rs);
    bit tick, ph_n, act, lit, e0, e1;
    int hold_n;
    string t0, t1;
    @(negedge clk);
    #1;
    led_mode = md; link_up = lk; speed_100 = sp; act_strobe = st; rst = rs;
    if (rs) begin
      m_cnt = 0; m_hold = 0; m_ph = 1'b0;
      e0 = 1'b1; e1 = 1'b1; t0 = "R1"; t1 = "R1";
    end else begin
      tick   = (m_cnt == P - 1);
      ph_n   = (m_hold == 0) ? 1'b0 : (tick ? ~m_ph : m_ph);
      hold_n = st ? H : ((tick && m_hold != 0) ? m_hold - 1 : m_hold);
      m_cnt  = tick ? 0 : m_cnt + 1;
      m_hold = hold_n;
      m_ph   = ph_n;
      act    = (hold_n != 0);
      lit    = act && !ph_n;
      case (md)
        2'b00: begin
          e0 = !(lk && !(act && ph_n));
          e1 = !sp;
          t0 = !lk ? "R3" : (act ? "R4" : "R3");
          t1 = "R2";
        end
        2'b01: begin
          e0 = !lk; e1 = !lit; t0 = "R5"; t1 = "R6";
        end
        default: begin
          e0 = 1'b1; e1 = 1'b1; t0 = "R7"; t1 = "R7";
        end
      endcase
    end
    q_e0.push_back(e0); q_e1.push_back(e1);
    q_t0.push_back({t0, " [", section, "]"});
    q_t1.push_back({t1, " [", section, "]"});
  endtask

  always @(negedge clk) begin
    if (q_e0.size() > 0) begin
      bit e0, e1;
      string t0, t1;
      e0 = q_e0.pop_front(); e1 = q_e1.pop_front();
      t0 = q_t0.pop_front(); t1 = q_t1.pop_front();
      checks += 2;
      if (led0_n !== e0) begin
        failures++;
        $display("FAIL %s led0_n got=%b exp=%b t=%0t", t0, led0_n, e0, $time);
      end
      if (led1_n !== e1) begin
        failures++;
        $display("FAIL %s led1_n got=%b exp=%b t=%0t", t1, led1_n, e1, $time);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired checks=%0d expected=completion", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    section = "R1 reset";
    for (int i = 0; i < 3; i++) step(2'b00, 0, 0, 0, 1);
    section = "R3 link down idle";
    for (int i = 0; i < 5; i++) step(2'b00, 0, 0, 0, 0);
    section = "R2 speed";
    for (int i = 0; i < 4; i++) step(2'b00, 0, 1, 0, 0);
    step(2'b00, 0, 0, 0, 0);
    step(2'b00, 0, 1, 0, 0);
    section = "R3 link up idle";
    for (int i = 0; i < 4; i++) step(2'b00, 1, 1, 0, 0);
    section = "R8 R10 single window";
    step(2'b00, 1, 1, 1, 0);
    for (int i = 0; i < 45; i++) step(2'b00, 1, 1, 0, 0);
    section = "R9 retrigger";
    step(2'b00, 1, 0, 1, 0);
    for (int i = 0; i < 13; i++) step(2'b00, 1, 0, 0, 0);
    step(2'b00, 1, 0, 1, 0);
    for (int i = 0; i < 7; i++) step(2'b00, 1, 0, 0, 0);
    step(2'b00, 1, 0, 1, 0);
    for (int i = 0; i < 40; i++) step(2'b00, 1, 0, 0, 0);
    section = "R3 strobes with link down";
    for (int i = 0; i < 30; i++) step(2'b00, 0, 1, (i % 5) == 0, 0);
    section = "R5 R6 split lamps";
    for (int i = 0; i < 6; i++) step(2'b01, i[1], 0, 0, 0);
    step(2'b01, 1, 1, 1, 0);
    for (int i = 0; i < 20; i++) step(2'b01, (i % 7) < 4, i[0], 0, 0);
    step(2'b01, 0, 0, 1, 0);
    section = "R10 expiry split";
    for (int i = 0; i < 40; i++) step(2'b01, 0, 0, 0, 0);
    section = "R7 reserved";
    for (int i = 0; i < 20; i++) step(2'b10, 1, 1, (i % 3) == 0, 0);
    for (int i = 0; i < 20; i++) step(2'b11, i[0], 1, (i % 4) == 0, 0);
    section = "R6 after reserved";
    for (int i = 0; i < 10; i++) step(2'b01, 1, 1, 0, 0);
    section = "R1 reset mid blink";
    step(2'b00, 1, 1, 1, 0);
    for (int i = 0; i < 6; i++) step(2'b00, 1, 1, 0, 0);
    step(2'b00, 1, 1, 0, 1);
    step(2'b00, 1, 1, 0, 1);
    section = "R6 idle after reset";
    for (int i = 0; i < 12; i++) step(2'b01, 1, 1, 0, 0);
    section = "R4 dense strobes";
    for (int i = 0; i < 60; i++) step(2'b00, 1, 1, (i % 11) == 0, 0);
    step(2'b00, 1, 1, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule